// File: doc/BRIEF.md
# Scatter-Gather Copy Engine

This block copies data from card-side memory to host-side buffers by following a chain of descriptors in host memory. Software writes the address of the first descriptor to the start register. The engine then reads each three-word descriptor, moves the byte count it names as 32-bit words, and goes on to the next descriptor until it finishes the one flagged as final. When the list ends, or when a descriptor carries a bad byte count, the engine raises an interrupt and leaves a sticky status that software reads and then clears.

Each descriptor is three consecutive 32-bit words: the card source address, the host destination address and a control word. Words move through two simple memory ports. Each port has a one-cycle read latency. The host port also serves descriptor fetches and data writes. Words pass through unchanged, so little-endian byte order is kept.

Top module: `sg_copy_engine`

## Requirements
- R1: After reset the engine is idle: no strobe on either memory port, status reads 0 and `irq` is low.
- R2: A write of base address B to offset 0x0 while idle starts the list. In the 1st, 2nd and 3rd cycles after that write, the engine issues host reads at B, B+4 and B+8: source, destination, control.
- R3: In the control word, bits 17:0 are the byte count, bit 31 is the last flag and bits 30:18 are ignored. The cycle after the control word is fetched issues no strobe.
- R4: A valid descriptor moves count/4 words, two cycles per word. For word k, a card read at source+4k is followed in the next cycle by a host write at destination+4k of that exact word, unchanged.
- R5: When a descriptor without the last flag finishes, the next descriptor is fetched from its address plus 12. The fetch starts in the cycle after the final write.
- R6: In the cycle after the final write of the last-flagged descriptor, done (status bit 1) and `irq` go high and busy (status bit 0) goes low.
- R7: A byte count of zero, or one that is not a multiple of 256, stops the list without moving data. In the cycle after the eval cycle, count error (status bit 2), done and `irq` are set.
- R8: A read at offset 0x4 returns the status: bit 0 busy, bit 1 done, bit 2 count error, all other bits 0.
- R9: Writing offset 0x4 with bit 1 set clears done, count error and `irq` from the next cycle. A write with bit 1 clear changes nothing.
- R10: A start write while busy is ignored. The running list goes on unchanged and no error is set.
- R11: A start accepted while done is set clears done and count error in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset (0x0 start/pointer, 0x4 status) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq | output | 1 | Completion interrupt, follows done |
| h_rd | output | 1 | Host port read strobe (descriptor fetch) |
| h_wr | output | 1 | Host port write strobe (data) |
| h_addr | output | 32 | Host port byte address |
| h_wdata | output | 32 | Host port write data |
| h_rdata | input | 32 | Host read data, valid the cycle after `h_rd` |
| c_rd | output | 1 | Card port read strobe |
| c_addr | output | 32 | Card port byte address |
| c_rdata | input | 32 | Card read data, valid the cycle after `c_rd` |

## Verification
Every result has a fixed cycle. The three descriptor reads fall 1 to 3 cycles after the start write. The eval cycle is 4 cycles after it. Each word then takes a read cycle and a write cycle. The interrupt appears one cycle after the final write, or one cycle after the eval cycle when the count is bad. A register write takes effect on the next cycle. The bench turns each start into a queue of per-cycle expected port states, pops one entry at every falling edge, and compares strobes, addresses, data, status and `irq` at that moment. A shift of even one cycle therefore shows up as a mismatch.

// File: rtl/sg_copy_engine.sv
module sg_copy_engine #(
  parameter int CNT_W      = 18,
  parameter int LAST_BIT   = 31,
  parameter int GRAN_BITS  = 8,
  parameter int DESC_BYTES = 12,
  parameter int STAT_OFS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        irq,
  output logic        h_rd,
  output logic        h_wr,
  output logic [31:0] h_addr,
  output logic [31:0] h_wdata,
  input  logic [31:0] h_rdata,
  output logic        c_rd,
  output logic [31:0] c_addr,
  input  logic [31:0] c_rdata
);
  localparam int WORD_W = CNT_W - 2;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_D0 = 3'd1, S_D1 = 3'd2, S_D2 = 3'd3,
    S_D3 = 3'd4, S_RD = 3'd5, S_WR = 3'd6
  } st_t;

  st_t               state;
  logic [31:0]       ptr, src, dst;
  logic [WORD_W-1:0] words;
  logic              last, done, err;

  logic [CNT_W-1:0]  cnt;
  logic              bad_cnt, busy, start, clr;

  assign cnt     = h_rdata[CNT_W-1:0];
  assign bad_cnt = (cnt == '0) || (|cnt[GRAN_BITS-1:0]);
  assign busy    = (state != S_IDLE);
  assign start   = cfg_wr && (cfg_addr == 4'd0) && !busy;
  assign clr     = cfg_wr && (cfg_addr == 4'(STAT_OFS)) && cfg_wdata[1];

  assign irq       = done;
  assign cfg_rdata = (cfg_addr == 4'(STAT_OFS)) ? {29'd0, err, done, busy}
                   : (cfg_addr == 4'd0) ? ptr : 32'd0;

  assign h_rd    = (state == S_D0) || (state == S_D1) || (state == S_D2);
  assign h_wr    = (state == S_WR);
  assign h_addr  = (state == S_WR) ? dst
                 : (state == S_D1) ? ptr + 32'd4
                 : (state == S_D2) ? ptr + 32'd8 : ptr;
  assign h_wdata = c_rdata;
  assign c_rd    = (state == S_RD);
  assign c_addr  = src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr   <= '0;
      src   <= '0;
      dst   <= '0;
      words <= '0;
      last  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (clr) begin
        done <= 1'b0;
        err  <= 1'b0;
      end
      case (state)
        S_IDLE: if (start) begin
          ptr   <= cfg_wdata;
          done  <= 1'b0;
          err   <= 1'b0;
          state <= S_D0;
        end
        S_D0: state <= S_D1;
        S_D1: begin
          src   <= h_rdata;
          state <= S_D2;
        end
        S_D2: begin
          dst   <= h_rdata;
          state <= S_D3;
        end
        S_D3: begin
          if (bad_cnt) begin
            err   <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            words <= cnt[CNT_W-1:2];
            last  <= h_rdata[LAST_BIT];
            state <= S_RD;
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          src   <= src + 32'd4;
          dst   <= dst + 32'd4;
          words <= words - 1'b1;
          if (words == WORD_W'(1)) begin
            if (last) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              ptr   <= ptr + 32'(DESC_BYTES);
              state <= S_D0;
            end
          end else begin
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_copy_engine_sva.sv
module sg_copy_engine_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [3:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        h_rd,
  input logic        h_wr,
  input logic        c_rd,
  input logic        irq,
  input logic        done,
  input logic        err,
  input logic [2:0]  st,
  input logic [31:0] ptr
);
  localparam logic [2:0] IDLE = 3'd0, D3 = 3'd4, WR = 3'd6;

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({h_rd, h_wr, c_rd}));

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr |-> $past(c_rd));

  assert_irq_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st == IDLE));

  assert_done_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st) == D3 || $past(st) == WR));

  assert_err_implies_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 4'd4 && cfg_wdata[1] && st == IDLE) |=> !irq);

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 4'd0 && st != IDLE && st != WR) |=> $stable(ptr));
endmodule

bind sg_copy_engine sg_copy_engine_sva chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .h_rd(h_rd), .h_wr(h_wr), .c_rd(c_rd), .irq(irq),
  .done(done), .err(err), .st(state), .ptr(ptr)
);

// File: tb/sg_copy_engine_test.sv
module sg_copy_engine_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_wr, irq, h_rd, h_wr, c_rd;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, h_addr, h_wdata, h_rdata, c_addr, c_rdata;

  sg_copy_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .c_rd(c_rd), .c_addr(c_addr), .c_rdata(c_rdata)
  );

  logic [31:0] dsc [0:255];

  function automatic logic [31:0] cword(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, ~a[17:2]};
  endfunction

  always @(posedge clk) begin
    if (h_rd) h_rdata <= dsc[h_addr[9:2]];
    if (c_rd) c_rdata <= cword(c_addr);
  end

  typedef struct packed {
    logic hrd, crd, hwr, fin, err;
    logic [31:0] addr, data;
  } ev_t;

  ev_t   q[$];
  string tq[$];
  int    checks = 0, fails = 0;
  logic  m_done = 1'b0, m_err = 1'b0;
  string idle_tag = "R1", ovr = "";

  function automatic void push(logic hrd, logic crd, logic hwr, logic fin, logic err,
                               logic [31:0] a, logic [31:0] d, string t);
    ev_t e;
    e.hrd = hrd; e.crd = crd; e.hwr = hwr; e.fin = fin; e.err = err;
    e.addr = a; e.data = d;
    q.push_back(e);
    tq.push_back(t);
  endfunction

  function automatic void build(logic [31:0] base);
    logic [31:0] p = base;
    for (int n = 0; n < 32; n++) begin
      logic [31:0] s, d, c;
      int cnt;
      push(1, 0, 0, 0, 0, p,         0, n == 0 ? "R2" : "R5");
      push(1, 0, 0, 0, 0, p + 32'd4, 0, n == 0 ? "R2" : "R5");
      push(1, 0, 0, 0, 0, p + 32'd8, 0, n == 0 ? "R2" : "R5");
      push(0, 0, 0, 0, 0, 0, 0, "R3");
      s = dsc[p[9:2]];
      d = dsc[p[9:2] + 8'd1];
      c = dsc[p[9:2] + 8'd2];
      cnt = int'(c[17:0]);
      if (cnt == 0 || cnt % 256 != 0) begin
        push(0, 0, 0, 1, 1, 0, 0, "R7");
        return;
      end
      for (int k = 0; k < cnt / 4; k++) begin
        push(0, 1, 0, 0, 0, s + 32'(4 * k), 0, "R4");
        push(0, 0, 1, 0, 0, d + 32'(4 * k), cword(s + 32'(4 * k)), "R4");
      end
      if (c[31]) begin
        push(0, 0, 0, 1, 0, 0, 0, "R6");
        return;
      end
      p = p + 32'd12;
    end
  endfunction

  task automatic compare();
    ev_t e;
    string t;
    logic [2:0] es;
    bit ok;
    if (q.size() > 0) begin
      e = q.pop_front();
      t = tq.pop_front();
      if (e.fin) begin
        m_done = 1'b1;
        m_err  = e.err;
      end
      es = e.fin ? {e.err, 1'b1, 1'b0} : 3'b001;
    end else begin
      e  = '0;
      t  = idle_tag;
      es = {m_err, m_done, 1'b0};
    end
    if (ovr != "") t = ovr;
    checks++;
    ok = (h_rd == e.hrd) && (c_rd == e.crd) && (h_wr == e.hwr) &&
         (cfg_rdata == {29'd0, es}) && (irq == es[1]);
    if (e.hrd || e.hwr) ok = ok && (h_addr == e.addr);
    if (e.crd)          ok = ok && (c_addr == e.addr);
    if (e.hwr)          ok = ok && (h_wdata == e.data);
    if (!ok) begin
      fails++;
      $display("FAIL %s (status R8) t=%0t actual rd/crd/wr=%b%b%b h_addr=%h c_addr=%h wdata=%h status=%h irq=%b expected rd/crd/wr=%b%b%b addr=%h data=%h status=%h irq=%b",
               t, $time, h_rd, c_rd, h_wr, h_addr, c_addr, h_wdata, cfg_rdata, irq,
               e.hrd, e.crd, e.hwr, e.addr, e.data, {29'd0, es}, es[1]);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    cfg_wr = 1'b0; cfg_addr = 4'd4; cfg_wdata = '0;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    repeat (n) cycle();
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    if (a == 4'd0 && q.size() == 0) begin
      m_done = 1'b0; m_err = 1'b0;
      build(d);
    end
    if (a == 4'd4 && d[1] && q.size() == 0) begin
      m_done = 1'b0; m_err = 1'b0;
    end
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    cycle();
  endtask

  task automatic run_out();
    while (q.size() > 0) cycle();
  endtask

  initial begin
    #(20 * 20000);
    $display("FAIL watchdog expired (all requirements) actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) dsc[i] = '0;
    // single last descriptor with reserved bits set (R3)
    dsc[0]  = 32'h0001_0000; dsc[1]  = 32'h2000_0000; dsc[2]  = 32'h8000_0000 | (32'h1ABC << 18) | 32'd256;
    // three-entry chain (R5)
    dsc[16] = 32'h0000_0100; dsc[17] = 32'h3000_0000; dsc[18] = 32'd512;
    dsc[19] = 32'h0000_2000; dsc[20] = 32'h3000_1000; dsc[21] = 32'd256;
    dsc[22] = 32'h0000_5000; dsc[23] = 32'h3000_2000; dsc[24] = 32'h8000_0000 | 32'd256;
    // good entry then misaligned count (R7)
    dsc[32] = 32'h0000_0700; dsc[33] = 32'h4000_0000; dsc[34] = 32'd256;
    dsc[35] = 32'h0000_0900; dsc[36] = 32'h4000_1000; dsc[37] = 32'h0000_0180;
    // zero count with last flag (R7)
    dsc[48] = 32'h0000_1000; dsc[49] = 32'h5000_0000; dsc[50] = 32'h8000_0000;
    // long entry for busy restart (R10)
    dsc[64] = 32'h0000_8000; dsc[65] = 32'h6000_0000; dsc[66] = 32'h8000_0000 | 32'd1024;

    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 4'd4; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    compare();
    idle(3);

    ovr = "R3"; wr(4'd0, 32'h0000_0000); run_out(); ovr = "";
    idle_tag = "R6"; idle(2);

    idle_tag = "R9";
    wr(4'd4, 32'h0000_0001); idle(1);
    wr(4'd4, 32'h0000_0002); idle(2);

    wr(4'd0, 32'h0000_0040); run_out();
    idle_tag = "R6"; idle(2);

    ovr = "R11"; wr(4'd0, 32'h0000_0080); ovr = "";
    run_out();
    idle_tag = "R7"; idle(2);

    idle_tag = "R9"; wr(4'd4, 32'h0000_0002);
    wr(4'd0, 32'h0000_00C0); run_out();
    idle_tag = "R7"; idle(2);

    idle_tag = "R9"; wr(4'd4, 32'h0000_0002);
    wr(4'd0, 32'h0000_0100); idle(20);
    ovr = "R10"; wr(4'd0, 32'h0000_0040); run_out(); ovr = "";
    idle_tag = "R10"; idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule